// File: doc/BRIEF.md
# Retired-Instruction Trace Packet Encoder

This block sits next to a processor core. It turns the core's stream of retired instructions into a compact stream of trace packets, and it never stalls the core. Each cycle the core may present one retire record: the program counter, a conditional-branch flag with its taken outcome, an indirect-jump flag, an exception flag and the current privilege level. Straight-line execution produces no packets, because a decoder that holds the program image can infer it. Conditional-branch outcomes are collected into a bit map. Indirect jumps are reported as a signed distance from the last reported address. Exceptions and privilege changes are reported with a full address.

Packets are queued in a small internal FIFO and leave on a valid/ready stream. Each packet carries a 2-bit format code, a 32-bit address field, an 8-bit outcome map, an outcome count and a privilege field. Synchronization packets give a decoder a full restart point. One is sent when tracing starts, after packets have been lost, and at a fixed interval of output packets. Software supplies an inclusive address window and a privilege mask, and records outside them are not traced.

Top module: `trace_pkt_enc`

## Requirements
- R1: While reset is asserted and right after it, `pkt_valid` and `overflow` are low.
- R2: The first accepted record after `trace_en` rises, or after reset, produces a synchronization packet (format 3) that carries the record's PC and privilege. Any outcome map that is still pending is sent ahead of it.
- R3: An accepted record that is not a conditional branch, not an indirect jump, not an exception and has no privilege change produces no packet.
- R4: Conditional-branch outcomes are stored in the map least significant bit first, with 1 meaning taken. When the eighth outcome arrives, one format-2 packet is sent. Its address is the PC of that eighth branch, its map holds the outcomes and its count field is 8. A map flushed early carries the PC of its last branch and the number of outcomes it holds.
- R5: An accepted indirect jump flushes any pending map. It then sends a format-1 packet whose address field is the jump PC minus the last reported address, as a 32-bit two's-complement value. The last reported address is the last branch PC if a map was flushed.
- R6: If that difference lies outside -32768..32767, a format-0 packet with the full PC is sent instead.
- R7: An exception, or a privilege level that differs from the last traced one, flushes any pending map, whose privilege field holds the old level. It then sends a format-0 packet with the PC and the new privilege.
- R8: A record is accepted only if `win_lo <= rt_pc <= win_hi` and `priv_en[rt_priv]` is set. Any other record changes nothing.
- R9: Once 256 non-synchronization packets have been queued since the last synchronization packet, the next accepted record produces a synchronization packet.
- R10: If the FIFO (8 entries) lacks room for all packets of a cycle, all of them are dropped, the pending map is cleared and `overflow` rises. The next packet queued is a synchronization packet, and `overflow` falls when it is queued.
- R11: Packets leave in the order they were formed. A packet is removed only when `pkt_valid` and `pkt_ready` are both high, and the head stays stable while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Tracing enable |
| rt_valid | input | 1 | Retire record present |
| rt_pc | input | 32 | PC of retired instruction |
| rt_branch | input | 1 | Instruction is a conditional branch |
| rt_taken | input | 1 | Branch outcome, 1 = taken |
| rt_jump | input | 1 | Instruction is an indirect jump |
| rt_exc | input | 1 | Exception taken on this instruction |
| rt_priv | input | 2 | Privilege level |
| win_lo | input | 32 | Filter window start, inclusive |
| win_hi | input | 32 | Filter window end, inclusive |
| priv_en | input | 4 | Per-privilege trace enable mask |
| pkt_valid | output | 1 | Packet available |
| pkt_ready | input | 1 | Consumer accepts packet |
| pkt_fmt | output | 2 | 0 full, 1 delta, 2 branch map, 3 sync |
| pkt_addr | output | 32 | PC or signed delta |
| pkt_map | output | 8 | Branch outcomes, oldest in bit 0 |
| pkt_cnt | output | 4 | Number of outcomes in map |
| pkt_priv | output | 2 | Privilege field |
| overflow | output | 1 | Packets lost since last sync |

## Verification
A record presented before a rising edge is encoded and queued at that edge. Its packets reach the FIFO head, and `overflow` changes, in time for the next falling edge. The bench drives every record at a falling edge and steps its reference model at the same point. It compares `pkt_valid`, `overflow` and each packet removed there against the model's queue. Because the model tracks FIFO occupancy edge by edge, the cycles in which packets are dropped and the synchronization that follows are predicted exactly, both for directed delta-range, filter and overflow cases and for a long seeded random stream.

// File: rtl/trace_pkg.sv
package trace_pkg;
    localparam int PC_W    = 32;
    localparam int MAP_LEN = 8;
    localparam int CNT_W   = $clog2(MAP_LEN + 1);
    localparam int PRIV_W  = 2;

    typedef enum logic [1:0] {
        FMT_FULL  = 2'd0,
        FMT_DELTA = 2'd1,
        FMT_MAP   = 2'd2,
        FMT_SYNC  = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e               fmt;
        logic [PC_W-1:0]    addr;
        logic [MAP_LEN-1:0] map;
        logic [CNT_W-1:0]   cnt;
        logic [PRIV_W-1:0]  priv;
    } pkt_t;
endpackage

// File: rtl/trace_filter.sv
module trace_filter
    import trace_pkg::*;
(
    input  logic [PC_W-1:0]      pc,
    input  logic [PRIV_W-1:0]    priv,
    input  logic [PC_W-1:0]      lo,
    input  logic [PC_W-1:0]      hi,
    input  logic [2**PRIV_W-1:0] priv_en,
    output logic                 pass
);
    always_comb begin
        pass = (pc >= lo) && (pc <= hi) && priv_en[priv];
    end
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo
    import trace_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push0,
    input  logic          push1,
    input  pkt_t          din0,
    input  pkt_t          din1,
    input  logic          pop,
    output pkt_t          dout,
    output logic          valid,
    output logic [CW-1:0] free
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t f_q, f_d;
    pkt_t mem [DEPTH];
    logic [AW-1:0] wp1;
    logic          do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d    = f_q;
        do_pop = pop && (f_q.cnt != '0);
        wp1    = bump(f_q.wp);
        if (do_pop) f_d.rp = bump(f_q.rp);
        if (push0)  f_d.wp = push1 ? bump(wp1) : wp1;
        f_d.cnt = f_q.cnt - CW'(do_pop) + CW'(push0) + CW'(push1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (push0) mem[f_q.wp] <= din0;
        if (push1) mem[wp1]    <= din1;
    end

    assign valid = (f_q.cnt != '0);
    assign dout  = mem[f_q.rp];
    assign free  = CW'(DEPTH) - f_q.cnt;

    // R10: the writer never exceeds the room it was offered
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(push0) + CW'(push1)) <= free);
    assert_push_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push1 |-> push0);
    // R11: a waiting head is held
    assert_head_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !pop) |=> (valid && $stable(dout)));
endmodule

// File: rtl/trace_pkt_form.sv
module trace_pkt_form
    import trace_pkg::*;
#(
    parameter int SYNC_PERIOD = 256,
    parameter int DELTA_W     = 16,
    parameter int DEPTH       = 8,
    localparam int CW  = $clog2(DEPTH + 1),
    localparam int SCW = $clog2(SYNC_PERIOD + 2) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic              acc,
    input  logic [PC_W-1:0]   pc,
    input  logic              branch,
    input  logic              taken,
    input  logic              jump,
    input  logic              exc,
    input  logic [PRIV_W-1:0] priv,
    input  logic [CW-1:0]     free,
    output logic              push0,
    output logic              push1,
    output pkt_t              pkt0,
    output pkt_t              pkt1,
    output logic              overflow
);
    typedef struct packed {
        logic               sync_pend;
        logic               ovf;
        logic [PRIV_W-1:0]  priv;
        logic [PC_W-1:0]    lastpc;
        logic [PC_W-1:0]    mpc;
        logic [MAP_LEN-1:0] map;
        logic [CNT_W-1:0]   mcnt;
        logic [SCW-1:0]     scnt;
    } est_t;

    est_t s_q, s_d;
    pkt_t flush_p, main_p, last_p;
    logic has_map, lead_flush, main_v, is_sync, fits;
    logic [1:0] npk;
    logic [PC_W-1:0] base, delta;
    logic [MAP_LEN-1:0] map_n;

    always_comb begin
        s_d        = s_q;
        lead_flush = 1'b0;
        main_v     = 1'b0;
        is_sync    = 1'b0;
        push0      = 1'b0;
        push1      = 1'b0;
        has_map    = (s_q.mcnt != '0);
        flush_p    = '{fmt: FMT_MAP, addr: s_q.mpc, map: s_q.map, cnt: s_q.mcnt, priv: s_q.priv};
        main_p     = '{fmt: FMT_FULL, addr: pc, map: '0, cnt: '0, priv: priv};
        map_n      = s_q.map | ({{(MAP_LEN-1){1'b0}}, taken} << s_q.mcnt);
        base       = has_map ? s_q.mpc : s_q.lastpc;
        delta      = pc - base;
        fits       = (&delta[PC_W-1:DELTA_W-1]) | ~(|delta[PC_W-1:DELTA_W-1]);

        if (!trace_en) begin
            s_d.sync_pend = 1'b1;
            s_d.map       = '0;
            s_d.mcnt      = '0;
        end else if (acc) begin
            if (s_q.sync_pend || exc || (priv != s_q.priv)) begin
                lead_flush = has_map;
                main_v     = 1'b1;
                is_sync    = s_q.sync_pend;
                if (s_q.sync_pend) main_p.fmt = FMT_SYNC;
                s_d.lastpc = pc;
                s_d.priv   = priv;
                s_d.map    = {{(MAP_LEN-1){1'b0}}, branch & taken};
                s_d.mcnt   = CNT_W'(branch);
                if (branch) s_d.mpc = pc;
            end else if (branch) begin
                s_d.mpc = pc;
                if (s_q.mcnt + 1'b1 == CNT_W'(MAP_LEN)) begin
                    main_v     = 1'b1;
                    main_p     = '{fmt: FMT_MAP, addr: pc, map: map_n, cnt: CNT_W'(MAP_LEN), priv: s_q.priv};
                    s_d.map    = '0;
                    s_d.mcnt   = '0;
                    s_d.lastpc = pc;
                end else begin
                    s_d.map  = map_n;
                    s_d.mcnt = s_q.mcnt + 1'b1;
                end
            end else if (jump) begin
                lead_flush = has_map;
                main_v     = 1'b1;
                if (fits) main_p = '{fmt: FMT_DELTA, addr: delta, map: '0, cnt: '0, priv: priv};
                s_d.lastpc = pc;
                s_d.map    = '0;
                s_d.mcnt   = '0;
            end
        end

        npk = {1'b0, lead_flush} + {1'b0, main_v};
        if (npk != 2'd0) begin
            if (CW'(npk) > free) begin
                s_d.ovf       = 1'b1;
                s_d.sync_pend = 1'b1;
                s_d.map       = '0;
                s_d.mcnt      = '0;
            end else begin
                push0 = 1'b1;
                push1 = (npk == 2'd2);
                if (is_sync) begin
                    s_d.scnt = '0;
                    s_d.ovf  = 1'b0;
                end else begin
                    s_d.scnt = s_q.scnt + SCW'(npk);
                end
                s_d.sync_pend = (s_d.scnt >= SCW'(SYNC_PERIOD));
            end
        end
        pkt0 = lead_flush ? flush_p : main_p;
        pkt1 = main_p;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.sync_pend <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign overflow = s_q.ovf;
    assign last_p   = push1 ? pkt1 : pkt0;

    // R2 / R9: a pending resync is served by the last packet queued
    assert_sync_served_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sync_pend && trace_en && push0) |-> (last_p.fmt == FMT_SYNC));
    // R10: after a loss the next queued packet restarts the decoder
    assert_resync_after_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && trace_en && push0) |-> (last_p.fmt == FMT_SYNC));
    assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && push0) |=> !overflow);
    // R4: a map packet never holds zero or more than MAP_LEN outcomes
    assert_map_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push0 && pkt0.fmt == FMT_MAP) |-> (pkt0.cnt != '0 && pkt0.cnt <= CNT_W'(MAP_LEN)));
    // R6: a delta packet always fits the signed field
    assert_delta_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push0 && last_p.fmt == FMT_DELTA) |->
        ((&last_p.addr[PC_W-1:DELTA_W-1]) || !(|last_p.addr[PC_W-1:DELTA_W-1])));
endmodule

// File: rtl/trace_pkt_enc.sv
module trace_pkt_enc
    import trace_pkg::*;
#(
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_PERIOD = 256,
    parameter int DELTA_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trace_en,
    input  logic                 rt_valid,
    input  logic [PC_W-1:0]      rt_pc,
    input  logic                 rt_branch,
    input  logic                 rt_taken,
    input  logic                 rt_jump,
    input  logic                 rt_exc,
    input  logic [PRIV_W-1:0]    rt_priv,
    input  logic [PC_W-1:0]      win_lo,
    input  logic [PC_W-1:0]      win_hi,
    input  logic [2**PRIV_W-1:0] priv_en,
    output logic                 pkt_valid,
    input  logic                 pkt_ready,
    output logic [1:0]           pkt_fmt,
    output logic [PC_W-1:0]      pkt_addr,
    output logic [MAP_LEN-1:0]   pkt_map,
    output logic [CNT_W-1:0]     pkt_cnt,
    output logic [PRIV_W-1:0]    pkt_priv,
    output logic                 overflow
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic          pass_w, acc_w, push0_w, push1_w;
    pkt_t          pkt0_w, pkt1_w, head_w;
    logic [CW-1:0] free_w;

    trace_filter u_filter (
        .pc(rt_pc), .priv(rt_priv), .lo(win_lo), .hi(win_hi),
        .priv_en(priv_en), .pass(pass_w)
    );

    assign acc_w = rt_valid && pass_w;

    trace_pkt_form #(
        .SYNC_PERIOD(SYNC_PERIOD), .DELTA_W(DELTA_W), .DEPTH(FIFO_DEPTH)
    ) u_form (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .acc(acc_w),
        .pc(rt_pc), .branch(rt_branch), .taken(rt_taken), .jump(rt_jump),
        .exc(rt_exc), .priv(rt_priv), .free(free_w),
        .push0(push0_w), .push1(push1_w), .pkt0(pkt0_w), .pkt1(pkt1_w),
        .overflow(overflow)
    );

    trace_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push0(push0_w), .push1(push1_w),
        .din0(pkt0_w), .din1(pkt1_w), .pop(pkt_ready), .dout(head_w),
        .valid(pkt_valid), .free(free_w)
    );

    assign pkt_fmt  = head_w.fmt;
    assign pkt_addr = head_w.addr;
    assign pkt_map  = head_w.map;
    assign pkt_cnt  = head_w.cnt;
    assign pkt_priv = head_w.priv;

    // R8: a record outside the window or privilege mask queues nothing
    assert_filter_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && !pass_w) |-> !push0_w);
endmodule

// File: tb/trace_pkt_enc_tb.sv
module trace_pkt_enc_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 8;
    localparam logic [31:0] LO = 32'h0000_1000;
    localparam logic [31:0] HI = 32'h00FF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trace_en = 1'b0, rt_valid = 1'b0, rt_branch = 1'b0, rt_taken = 1'b0;
    logic rt_jump = 1'b0, rt_exc = 1'b0, pkt_ready = 1'b0;
    logic [31:0] rt_pc = '0;
    logic [1:0] rt_priv = 2'd3;
    logic [31:0] win_lo = LO, win_hi = HI;
    logic [3:0] priv_en = 4'b1011;
    logic pkt_valid, overflow;
    logic [1:0] pkt_fmt, pkt_priv;
    logic [31:0] pkt_addr;
    logic [7:0] pkt_map;
    logic [3:0] pkt_cnt;

    int n_chk = 0, n_fail = 0, n_r9 = 0;

    // reference model state
    int m_cnt = 0, m_mc = 0, m_sc = 0;
    bit m_sync = 1'b1, m_ovf = 1'b0;
    bit [1:0] m_priv = 2'd0;
    bit [31:0] m_last = '0, m_mpc = '0;
    bit [7:0] m_map = '0;
    string m_why = "R2";
    logic [47:0] expq[$];
    string tagq[$];

    always #10 clk = ~clk;

    trace_pkt_enc u_dut (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .rt_valid(rt_valid),
        .rt_pc(rt_pc), .rt_branch(rt_branch), .rt_taken(rt_taken), .rt_jump(rt_jump),
        .rt_exc(rt_exc), .rt_priv(rt_priv), .win_lo(win_lo), .win_hi(win_hi),
        .priv_en(priv_en), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_fmt(pkt_fmt), .pkt_addr(pkt_addr), .pkt_map(pkt_map), .pkt_cnt(pkt_cnt),
        .pkt_priv(pkt_priv), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] mk(input bit [1:0] f, input bit [31:0] a, input bit [7:0] mp,
                                       input int c, input bit [1:0] p);
        return {f, a, mp, 4'(c), p};
    endfunction

    function automatic void mstep(input bit en, input bit v, input bit [31:0] pc, input bit br,
                                  input bit tk, input bit jp, input bit ex, input bit [1:0] pv,
                                  input bit rdy);
        int free = DEPTH - m_cnt;
        int pop = (m_cnt > 0 && rdy) ? 1 : 0;
        logic [47:0] pk[2];
        string tg[2];
        int n = 0;
        bit sy = 1'b0;
        bit [31:0] base, d;
        logic [47:0] fl = mk(2'd2, m_mpc, m_map, m_mc, m_priv);
        if (!en) begin
            m_sync = 1'b1; m_mc = 0; m_map = '0; m_why = "R2";
        end else if (v && pc >= LO && pc <= HI && priv_en[pv]) begin
            if (m_sync || ex || pv != m_priv) begin
                if (m_mc != 0) begin pk[n] = fl; tg[n] = "R4"; n++; end
                pk[n] = mk(m_sync ? 2'd3 : 2'd0, pc, 8'h0, 0, pv);
                tg[n] = m_sync ? m_why : "R7"; n++;
                sy = m_sync;
                m_last = pc; m_priv = pv; m_map = '0; m_mc = 0;
                if (br) begin m_map[0] = tk; m_mc = 1; m_mpc = pc; end
            end else if (br) begin
                m_map[m_mc] = tk; m_mc++; m_mpc = pc;
                if (m_mc == 8) begin
                    pk[n] = mk(2'd2, pc, m_map, 8, m_priv); tg[n] = "R4"; n++;
                    m_map = '0; m_mc = 0; m_last = pc;
                end
            end else if (jp) begin
                base = (m_mc != 0) ? m_mpc : m_last;
                d = pc - base;
                if (m_mc != 0) begin pk[n] = fl; tg[n] = "R4"; n++; end
                if ($signed(d) >= -32768 && $signed(d) <= 32767) begin
                    pk[n] = mk(2'd1, d, 8'h0, 0, pv); tg[n] = "R5";
                end else begin
                    pk[n] = mk(2'd0, pc, 8'h0, 0, pv); tg[n] = "R6";
                end
                n++;
                m_last = pc; m_map = '0; m_mc = 0;
            end
        end
        if (n > 0) begin
            if (n > free) begin
                m_ovf = 1'b1; m_sync = 1'b1; m_map = '0; m_mc = 0; m_why = "R10"; n = 0;
            end else begin
                for (int i = 0; i < n; i++) begin expq.push_back(pk[i]); tagq.push_back(tg[i]); end
                if (sy) begin m_sc = 0; m_ovf = 1'b0; end
                else m_sc += n;
                if (m_sc >= 256) begin m_sync = 1'b1; m_why = "R9"; end
                else m_sync = 1'b0;
            end
        end
        m_cnt = m_cnt - pop + n;
    endfunction

    // one cycle: drive at the falling edge, check the state left by the previous rising edge
    task automatic step(input bit en, input bit v, input logic [31:0] pc, input bit br, input bit tk,
                        input bit jp, input bit ex, input logic [1:0] pv, input bit rdy);
        logic [47:0] e;
        string t;
        trace_en = en; rt_valid = v; rt_pc = pc; rt_branch = br; rt_taken = tk;
        rt_jump = jp; rt_exc = ex; rt_priv = pv; pkt_ready = rdy;
        chk(pkt_valid === (m_cnt != 0), "R11 valid", 64'(pkt_valid), 64'(m_cnt != 0));
        chk(overflow === m_ovf, "R10 flag", 64'(overflow), 64'(m_ovf));
        if (m_cnt != 0 && rdy) begin
            e = expq.pop_front();
            t = tagq.pop_front();
            chk({pkt_fmt, pkt_addr, pkt_map, pkt_cnt, pkt_priv} === e, t,
                64'({pkt_fmt, pkt_addr, pkt_map, pkt_cnt, pkt_priv}), 64'(e));
            if (t == "R9") n_r9++;
        end
        mstep(en, v, pc, br, tk, jp, ex, pv, rdy);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit rdy);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, m_priv, rdy);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit [7:0] pat;
        logic [31:0] pc;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pkt_valid === 1'b0 && overflow === 1'b0, "R1", 64'({pkt_valid, overflow}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(pkt_valid === 1'b0 && overflow === 1'b0, "R1", 64'({pkt_valid, overflow}), 64'(0));

        // R2: first record after enable; R3: sequential records are silent
        step(1, 1, 32'h2000, 0, 0, 0, 0, 2'd3, 1);
        for (int i = 1; i <= 4; i++) step(1, 1, 32'h2000 + 32'(4 * i), 0, 0, 0, 0, 2'd3, 1);
        idle(2, 1);
        chk(pkt_valid === 1'b0, "R3", 64'(pkt_valid), 64'(0));

        // R4: eight outcomes -> map 8'b10110010
        pat = 8'b1011_0010;
        for (int i = 0; i < 8; i++) step(1, 1, 32'h2100 + 32'(4 * i), 1, pat[i], 0, 0, 2'd3, 1);
        idle(2, 1);

        // R4 + R7: partial map flushed by an exception
        for (int i = 0; i < 3; i++) step(1, 1, 32'h2200 + 32'(4 * i), 1, i[0], 0, 0, 2'd3, 1);
        step(1, 1, 32'h3000, 0, 0, 0, 1, 2'd3, 1);
        idle(3, 1);

        // R5 / R6: delta range edges
        step(1, 1, 32'h3000 + 32'd32767, 0, 0, 1, 0, 2'd3, 1);
        step(1, 1, 32'hAFFF + 32'd32768, 0, 0, 1, 0, 2'd3, 1);
        step(1, 1, 32'h12FFF - 32'd32768, 0, 0, 1, 0, 2'd3, 1);
        step(1, 1, 32'hAFFF - 32'd32769, 0, 0, 1, 0, 2'd3, 1);
        for (int i = 0; i < 2; i++) step(1, 1, 32'h2F00 + 32'(4 * i), 1, 1, 0, 0, 2'd3, 1);
        step(1, 1, 32'h2F40, 0, 0, 1, 0, 2'd3, 1);
        idle(3, 1);

        // R7: privilege changes, one with a map pending
        step(1, 1, 32'h3100, 0, 0, 0, 0, 2'd1, 1);
        step(1, 1, 32'h3104, 1, 1, 0, 0, 2'd1, 1);
        step(1, 1, 32'h3108, 1, 0, 0, 0, 2'd1, 1);
        step(1, 1, 32'h310C, 0, 0, 0, 0, 2'd3, 1);
        idle(3, 1);

        // R8: filtered records change nothing
        step(1, 1, LO - 1, 0, 0, 1, 0, 2'd3, 1);
        step(1, 1, HI + 1, 0, 0, 0, 1, 2'd3, 1);
        step(1, 1, 32'h4000, 0, 0, 1, 1, 2'd2, 1);
        idle(2, 1);
        chk(pkt_valid === 1'b0, "R8", 64'(pkt_valid), 64'(0));
        step(1, 1, HI, 0, 0, 1, 0, 2'd3, 1);
        step(1, 1, LO, 0, 0, 1, 0, 2'd3, 1);
        idle(3, 1);

        // R10: overflow with the consumer stalled
        for (int i = 0; i < 12; i++)
            step(1, 1, (i % 2 == 0) ? 32'h0080_0000 : 32'h0000_2000, 0, 0, 1, 0, 2'd3, 0);
        chk(overflow === 1'b1, "R10", 64'(overflow), 64'(1));
        idle(10, 1);
        step(1, 1, 32'h5000, 0, 0, 0, 0, 2'd3, 1);
        idle(2, 1);
        chk(overflow === 1'b0, "R10", 64'(overflow), 64'(0));

        // R2: re-enable
        for (int i = 0; i < 3; i++) step(0, 1, 32'h5100, 0, 0, 1, 0, 2'd3, 1);
        step(1, 1, 32'h5200, 0, 0, 0, 0, 2'd3, 1);
        idle(2, 1);

        // random phase (R9 periodic sync among others)
        pc = 32'h1_0000;
        for (int c = 0; c < 30000; c++) begin
            int r = int'($urandom % 100);
            bit rdy = ($urandom % 4) != 0;
            bit v = ($urandom % 8) != 0;
            bit en = ($urandom % 3000) != 0;
            logic [1:0] pv = m_priv;
            logic [31:0] ipc;
            bit br = 0, tk = 0, jp = 0, ex = 0;
            pc = pc + 4;
            if (r < 20) begin br = 1; tk = $urandom % 2; end
            else if (r < 25) begin
                jp = 1;
                if ($urandom % 2) pc = pc + 32'(int'($urandom % 70000) - 35000);
                else pc = LO + ($urandom % 32'h00FF_0000);
            end
            else if (r < 26) ex = 1;
            else if (r < 27) pv = 2'($urandom % 4);
            if (pc < 32'h2000 || pc > 32'h00F0_0000) pc = 32'h1_0000;
            ipc = (r >= 27 && r < 29) ? HI + 32'($urandom % 256) + 1 : pc;
            step(en, v, ipc, br, tk, jp, ex, pv, rdy);
        end
        idle(20, 1);
        chk(n_r9 > 0, "R9", 64'(n_r9), 64'(1));
        chk(expq.size() == 0 && pkt_valid === 1'b0, "R11 drained", 64'(expq.size()), 64'(0));

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule